// File: doc/BRIEF.md
# Route-Unit Lending Controller

This block coordinates the five route-computation units of a mesh router, one per input port (east, west, north, south, local). A unit is busy only while it resolves a head flit; body and tail flits never use it, so an idle unit can be lent. When a port's own unit is marked faulty and a head flit arrives, the controller picks an idle unit belonging to a peer port in the same cycle. It claims that unit for the borrower, loads the borrower's destination and identity into it, and returns the computed output port to the borrower once the lender has finished.

If no peer unit is free in that cycle, the controller does not wait. It reports a fallback: the head flit leaves on the lookahead route it already carries, and a double-routing flag tells the next router to compute two hops. Both the borrowed path and the fallback cost one cycle more than a healthy local computation. Fault indications come from external checkers. The routing function is dimension-ordered XY, applied to a hop coordinate supplied by the surrounding router.

Top module: `rcb_ctrl`

## Requirements
- R1: After reset every unit state reads idle (code 0), and no port shows a valid result or a stall.
- R2: A healthy idle port that receives a head request gives its result one cycle later, with the double-routing flag low. The route codes are east 0, west 1, north 2, south 3, local 4. The result is east if the destination x is above the hop x and west if it is below. With x equal, it is north if the destination y is above the hop y and south if it is below. It is local if both coordinates match.
- R3: A fault pulse on a port sets its unit state to faulty (code 3) from the next cycle, and the state stays faulty until reset.
- R4: A head request on a faulty port claims the lowest-numbered unit that is idle and has no request from its own port in that cycle. In the next cycle that unit reads active-for-another-port (code 2), and its 3-bit borrower field holds the borrower's port code (east 0 to local 4).
- R5: A borrowed result appears on the borrower's port two cycles after its request, with the double-routing flag low. In that same cycle the lender reads idle again.
- R6: When several faulty ports request in one cycle, they are served in ascending port order, each by a distinct lender.
- R7: When a faulty port finds no lendable unit, one cycle later its result is valid with the double-routing flag high, and the port reported is the lookahead route it presented with the request.
- R8: A head request on a port whose own unit is lent out raises that port's stall output in the same cycle, and the request is not accepted. No result follows, and the port must present the request again.
- R9: A unit that accepts its own port's head flit reads active-for-own-port (code 1), with its borrower field equal to its own port code, in the following cycle. It reads idle the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hop_x_i | input | COORD_W | X coordinate of the hop being routed |
| hop_y_i | input | COORD_W | Y coordinate of the hop being routed |
| hd_req_i | input | 5 | Per-port head-flit route request, one-cycle pulse |
| dst_x_i | input | 5*COORD_W | Per-port destination X |
| dst_y_i | input | 5*COORD_W | Per-port destination Y |
| la_route_i | input | 15 | Per-port lookahead route carried by the head flit |
| fault_i | input | 5 | Per-port unit fault indication from the checkers |
| stall_o | output | 5 | Request refused because the port's own unit is lent |
| rt_vld_o | output | 5 | Per-port result valid pulse |
| rt_dbl_o | output | 5 | Result is a fallback; next router must route two hops |
| rt_port_o | output | 15 | Per-port resulting output port code |
| unit_state_o | output | 10 | Per-unit state code |
| unit_bp_o | output | 15 | Per-unit borrower field |

## Verification
The properties take for granted that a port issues no new head request until its previous one has a result or a stall, and that a fault pulse never coincides with a request or with a unit that is busy. They also assume the hop coordinate stays steady while a lent unit is computing. The directed tasks honour all three. Each task resets the block and raises faults in a cycle of their own before any request. It issues a port's next request only after observing that port's result or stall, and holds the hop coordinate fixed for the whole scenario.

// File: rtl/rcb_pkg.sv
`timescale 1ns/1ps
package rcb_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOCAL  = 2'd1,
    ST_LENT   = 2'd2,
    ST_FAULTY = 2'd3
  } unit_st_e;

  localparam logic [PW-1:0] DIR_E = 3'd0;
  localparam logic [PW-1:0] DIR_W = 3'd1;
  localparam logic [PW-1:0] DIR_N = 3'd2;
  localparam logic [PW-1:0] DIR_S = 3'd3;
  localparam logic [PW-1:0] DIR_L = 3'd4;

  // dimension-ordered route: resolve x first, then y
  function automatic logic [PW-1:0] xy_route(input logic [7:0] hx, input logic [7:0] hy,
                                             input logic [7:0] dx, input logic [7:0] dy);
    if (dx > hx)      return DIR_E;
    else if (dx < hx) return DIR_W;
    else if (dy > hy) return DIR_N;
    else if (dy < hy) return DIR_S;
    else              return DIR_L;
  endfunction
endpackage

// File: rtl/rcb_unit.sv
`timescale 1ns/1ps
module rcb_unit import rcb_pkg::*; #(
  parameter int COORD_W = 3,
  parameter int SELF_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic               take_loc_i,
  input  logic               take_glb_i,
  input  logic [COORD_W-1:0] hop_x_i,
  input  logic [COORD_W-1:0] hop_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  logic [PW-1:0]      bor_id_i,
  output logic [1:0]         state_o,
  output logic [PW-1:0]      bp_o,
  output logic [PW-1:0]      rr_o
);
  unit_st_e           st_q;
  logic [COORD_W-1:0] drx_q, dry_q;
  logic [PW-1:0]      bp_q, rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      drx_q <= '0;
      dry_q <= '0;
      bp_q  <= '0;
      rr_q  <= '0;
    end else if (fault_i) begin
      st_q <= ST_FAULTY;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (take_loc_i) begin
            st_q  <= ST_LOCAL;
            drx_q <= dst_x_i;
            dry_q <= dst_y_i;
            bp_q  <= PW'(SELF_ID);
            rr_q  <= xy_route(8'(hop_x_i), 8'(hop_y_i), 8'(dst_x_i), 8'(dst_y_i));
          end else if (take_glb_i) begin
            st_q  <= ST_LENT;
            drx_q <= dst_x_i;
            dry_q <= dst_y_i;
            bp_q  <= bor_id_i;
          end
        end
        ST_LOCAL: st_q <= ST_IDLE;
        ST_LENT: begin
          st_q <= ST_IDLE;
          rr_q <= xy_route(8'(hop_x_i), 8'(hop_y_i), 8'(drx_q), 8'(dry_q));
        end
        default: st_q <= ST_FAULTY;
      endcase
    end
  end

  assign state_o = st_q;
  assign bp_o    = bp_q;
  assign rr_o    = rr_q;
endmodule

// File: rtl/rcb_alloc.sv
`timescale 1ns/1ps
module rcb_alloc import rcb_pkg::*; (
  input  logic [NPORT-1:0]    req_i,
  input  logic [NPORT*2-1:0]  st_i,
  output logic [NPORT-1:0]    take_loc_o,
  output logic [NPORT-1:0]    take_glb_o,
  output logic [NPORT-1:0]    stall_o,
  output logic [NPORT-1:0]    fb_o,
  output logic [NPORT-1:0]    grant_o,
  output logic [NPORT*PW-1:0] bor_id_o,
  output logic [NPORT*PW-1:0] lend_id_o
);
  logic [NPORT-1:0] idle_w, flty_w, busy_w, free_w, taken_w;

  always_comb begin
    for (int u = 0; u < NPORT; u++) begin
      idle_w[u] = (st_i[u*2 +: 2] == ST_IDLE);
      flty_w[u] = (st_i[u*2 +: 2] == ST_FAULTY);
      busy_w[u] = (st_i[u*2 +: 2] == ST_LOCAL) || (st_i[u*2 +: 2] == ST_LENT);
    end
    take_loc_o = req_i & idle_w;
    stall_o    = req_i & busy_w;
    free_w     = idle_w & ~req_i;
  end

  // borrowers in ascending port order, each takes the lowest free unit left
  always_comb begin
    logic found;
    taken_w    = '0;
    take_glb_o = '0;
    fb_o       = '0;
    grant_o    = '0;
    bor_id_o   = '0;
    lend_id_o  = '0;
    for (int b = 0; b < NPORT; b++) begin
      found = 1'b0;
      if (req_i[b] && flty_w[b]) begin
        for (int u = 0; u < NPORT; u++) begin
          if (!found && free_w[u] && !taken_w[u]) begin
            found                  = 1'b1;
            taken_w[u]             = 1'b1;
            take_glb_o[u]          = 1'b1;
            bor_id_o[u*PW +: PW]   = PW'(b);
            lend_id_o[b*PW +: PW]  = PW'(u);
          end
        end
        grant_o[b] = found;
        fb_o[b]    = !found;
      end
    end
  end
endmodule

// File: rtl/rcb_ctrl.sv
`timescale 1ns/1ps
module rcb_ctrl import rcb_pkg::*; #(
  parameter int COORD_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [COORD_W-1:0]         hop_x_i,
  input  logic [COORD_W-1:0]         hop_y_i,
  input  logic [NPORT-1:0]           hd_req_i,
  input  logic [NPORT*COORD_W-1:0]   dst_x_i,
  input  logic [NPORT*COORD_W-1:0]   dst_y_i,
  input  logic [NPORT*PW-1:0]        la_route_i,
  input  logic [NPORT-1:0]           fault_i,
  output logic [NPORT-1:0]           stall_o,
  output logic [NPORT-1:0]           rt_vld_o,
  output logic [NPORT-1:0]           rt_dbl_o,
  output logic [NPORT*PW-1:0]        rt_port_o,
  output logic [NPORT*2-1:0]         unit_state_o,
  output logic [NPORT*PW-1:0]        unit_bp_o
);
  // named internal events, also observed by the bound checker
  logic [NPORT-1:0]    take_loc, take_glb, fb_now, grant;
  logic [NPORT*PW-1:0] bor_id, lend_id, rr_flat;
  logic [NPORT-1:0]    loc_q, brw1_q, brw2_q, fb_q;
  logic [NPORT*PW-1:0] lend_q, fbp_q;

  rcb_alloc u_alloc (
    .req_i      (hd_req_i),
    .st_i       (unit_state_o),
    .take_loc_o (take_loc),
    .take_glb_o (take_glb),
    .stall_o    (stall_o),
    .fb_o       (fb_now),
    .grant_o    (grant),
    .bor_id_o   (bor_id),
    .lend_id_o  (lend_id)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_unit
    logic [COORD_W-1:0] ux, uy;
    always_comb begin
      ux = dst_x_i[g*COORD_W +: COORD_W];
      uy = dst_y_i[g*COORD_W +: COORD_W];
      if (take_glb[g]) begin
        for (int k = 0; k < NPORT; k++) begin
          if (bor_id[g*PW +: PW] == PW'(k)) begin
            ux = dst_x_i[k*COORD_W +: COORD_W];
            uy = dst_y_i[k*COORD_W +: COORD_W];
          end
        end
      end
    end

    rcb_unit #(.COORD_W(COORD_W), .SELF_ID(g)) u_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_i    (fault_i[g]),
      .take_loc_i (take_loc[g]),
      .take_glb_i (take_glb[g]),
      .hop_x_i    (hop_x_i),
      .hop_y_i    (hop_y_i),
      .dst_x_i    (ux),
      .dst_y_i    (uy),
      .bor_id_i   (bor_id[g*PW +: PW]),
      .state_o    (unit_state_o[g*2 +: 2]),
      .bp_o       (unit_bp_o[g*PW +: PW]),
      .rr_o       (rr_flat[g*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q  <= '0;
      brw1_q <= '0;
      brw2_q <= '0;
      fb_q   <= '0;
      lend_q <= '0;
      fbp_q  <= '0;
    end else begin
      loc_q  <= take_loc;
      brw1_q <= grant;
      brw2_q <= brw1_q;
      fb_q   <= fb_now;
      for (int p = 0; p < NPORT; p++) begin
        if (grant[p])  lend_q[p*PW +: PW] <= lend_id[p*PW +: PW];
        if (fb_now[p]) fbp_q[p*PW +: PW]  <= la_route_i[p*PW +: PW];
      end
    end
  end

  always_comb begin
    rt_vld_o  = loc_q | brw2_q | fb_q;
    rt_dbl_o  = fb_q;
    rt_port_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (loc_q[p]) begin
        rt_port_o[p*PW +: PW] = rr_flat[p*PW +: PW];
      end else if (brw2_q[p]) begin
        for (int k = 0; k < NPORT; k++)
          if (lend_q[p*PW +: PW] == PW'(k)) rt_port_o[p*PW +: PW] = rr_flat[k*PW +: PW];
      end else begin
        rt_port_o[p*PW +: PW] = fbp_q[p*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/rcb_ctrl_chk.sv
`timescale 1ns/1ps
module rcb_ctrl_chk import rcb_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic [NPORT-1:0]    req,
  input logic [NPORT*2-1:0]  st_flat,
  input logic [NPORT*PW-1:0] bp_flat,
  input logic [NPORT*PW-1:0] bor_id,
  input logic [NPORT-1:0]    take_loc,
  input logic [NPORT-1:0]    take_glb,
  input logic [NPORT-1:0]    grant,
  input logic [NPORT-1:0]    fb,
  input logic [NPORT-1:0]    stall,
  input logic [NPORT-1:0]    rt_vld,
  input logic [NPORT-1:0]    rt_dbl
);
  AST_LENDERS_MATCH_BORROWERS: assert property (@(posedge clk) disable iff (!rst_n) $countones(take_glb) == $countones(grant)); // R6

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    AST_LEND_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n) take_glb[g] |-> (st_flat[g*2 +: 2] == ST_IDLE) && !req[g]); // R4
    AST_LEND_LOADS_BP: assert property (@(posedge clk) disable iff (!rst_n) take_glb[g] |=> (st_flat[g*2 +: 2] == ST_LENT) && (bp_flat[g*PW +: PW] == $past(bor_id[g*PW +: PW]))); // R4
    AST_LENT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (st_flat[g*2 +: 2] == ST_LENT) |=> (st_flat[g*2 +: 2] == ST_IDLE)); // R5
    AST_BORROW_RESULT: assert property (@(posedge clk) disable iff (!rst_n) grant[g] |=> ##1 (rt_vld[g] && !rt_dbl[g])); // R5
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (st_flat[g*2 +: 2] == ST_FAULTY) |=> (st_flat[g*2 +: 2] == ST_FAULTY)); // R3
    AST_FALLBACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n) fb[g] |=> (rt_vld[g] && rt_dbl[g])); // R7
    AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) stall[g] |=> (st_flat[g*2 +: 2] != ST_LOCAL)); // R8
    AST_LOCAL_STATE: assert property (@(posedge clk) disable iff (!rst_n) take_loc[g] |=> (st_flat[g*2 +: 2] == ST_LOCAL) && (bp_flat[g*PW +: PW] == PW'(g)) && rt_vld[g] && !rt_dbl[g]); // R9
  end
endmodule

bind rcb_ctrl rcb_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (hd_req_i),
  .st_flat  (unit_state_o),
  .bp_flat  (unit_bp_o),
  .bor_id   (bor_id),
  .take_loc (take_loc),
  .take_glb (take_glb),
  .grant    (grant),
  .fb       (fb_now),
  .stall    (stall_o),
  .rt_vld   (rt_vld_o),
  .rt_dbl   (rt_dbl_o)
);

// File: tb/rcb_ctrl_tb_top.sv
`timescale 1ns/1ps
module rcb_ctrl_tb_top;
  localparam int NP = 5;
  localparam int CW = 3;
  localparam int PW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [CW-1:0]   hop_x = '0, hop_y = '0;
  logic [NP-1:0]   hd_req = '0;
  logic [NP*CW-1:0] dst_x = '0, dst_y = '0;
  logic [NP*PW-1:0] la_route = '0;
  logic [NP-1:0]   fault = '0;
  logic [NP-1:0]   stall, rt_vld, rt_dbl;
  logic [NP*PW-1:0] rt_port, unit_bp;
  logic [NP*2-1:0] unit_state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rcb_ctrl #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hop_x_i(hop_x), .hop_y_i(hop_y),
    .hd_req_i(hd_req), .dst_x_i(dst_x), .dst_y_i(dst_y), .la_route_i(la_route),
    .fault_i(fault), .stall_o(stall), .rt_vld_o(rt_vld), .rt_dbl_o(rt_dbl),
    .rt_port_o(rt_port), .unit_state_o(unit_state), .unit_bp_o(unit_bp)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int st(input int p);   return int'(unit_state[p*2 +: 2]); endfunction
  function automatic int bpf(input int p);  return int'(unit_bp[p*PW +: PW]); endfunction
  function automatic int prt(input int p);  return int'(rt_port[p*PW +: PW]); endfunction

  // expected XY decision from signed offsets
  function automatic int want_dir(input int hx, input int hy, input int dx, input int dy);
    int ox = dx - hx;
    int oy = dy - hy;
    if (ox != 0) return (ox > 0) ? 0 : 1;
    if (oy != 0) return (oy > 0) ? 2 : 3;
    return 4;
  endfunction

  task automatic set_dst(input int p, input int x, input int y);
    dst_x[p*CW +: CW] = CW'(x);
    dst_y[p*CW +: CW] = CW'(y);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    hd_req = '0; fault = '0;
    rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic mark_faulty(input logic [NP-1:0] m);
    fault = m;
    cyc();
    fault = '0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int p = 0; p < NP; p++) begin
      check("R1", "state idle", st(p), 0);
      check("R1", "rt_vld low", int'(rt_vld[p]), 0);
      check("R1", "stall low", int'(stall[p]), 0);
    end
  endtask

  task automatic one_local(input int p, input int hx, input int hy, input int dx, input int dy);
    hop_x = CW'(hx); hop_y = CW'(hy);
    set_dst(p, dx, dy);
    hd_req[p] = 1'b1;
    cyc();
    hd_req[p] = 1'b0;
    check("R2", "local vld", int'(rt_vld[p]), 1);
    check("R2", "local port", prt(p), want_dir(hx, hy, dx, dy));
    check("R2", "local dbl", int'(rt_dbl[p]), 0);
    check("R9", "own-active state", st(p), 1);
    check("R9", "own bp", bpf(p), p);
    cyc();
    check("R9", "back to idle", st(p), 0);
  endtask

  task automatic t_local();
    do_reset();
    one_local(0, 3, 3, 6, 1);
    one_local(1, 3, 3, 0, 5);
    one_local(2, 2, 2, 2, 6);
    one_local(3, 4, 4, 4, 0);
    one_local(4, 1, 5, 1, 5);
  endtask

  task automatic t_fault_mark();
    do_reset();
    mark_faulty(5'b00010);
    check("R3", "faulty state", st(1), 3);
    check("R3", "others idle", st(0), 0);
    cyc(); cyc(); cyc();
    check("R3", "faulty sticky", st(1), 3);
  endtask

  task automatic t_borrow();
    do_reset();
    hop_x = 3'd3; hop_y = 3'd3;
    mark_faulty(5'b00010);
    set_dst(1, 3, 7);
    hd_req[1] = 1'b1;
    cyc();
    hd_req[1] = 1'b0;
    check("R4", "lender state", st(0), 2);
    check("R4", "lender bp", bpf(0), 1);
    check("R5", "no early result", int'(rt_vld[1]), 0);
    cyc();
    check("R5", "borrow vld", int'(rt_vld[1]), 1);
    check("R5", "borrow port", prt(1), want_dir(3, 3, 3, 7));
    check("R5", "borrow dbl", int'(rt_dbl[1]), 0);
    check("R5", "lender idle", st(0), 0);
  endtask

  task automatic t_borrow_skip();
    do_reset();
    hop_x = 3'd3; hop_y = 3'd3;
    mark_faulty(5'b00010);
    set_dst(0, 0, 3);
    set_dst(1, 3, 0);
    hd_req = 5'b00011;
    cyc();
    hd_req = '0;
    check("R4", "requesting unit kept local", st(0), 1);
    check("R4", "next unit lent", st(2), 2);
    check("R4", "lent bp", bpf(2), 1);
    check("R2", "local port W", prt(0), 1);
    cyc();
    check("R5", "borrow vld", int'(rt_vld[1]), 1);
    check("R5", "borrow port S", prt(1), 3);
  endtask

  task automatic t_multi();
    do_reset();
    hop_x = 3'd3; hop_y = 3'd3;
    mark_faulty(5'b01010);
    set_dst(0, 5, 5);
    set_dst(1, 7, 3);
    set_dst(3, 3, 3);
    hd_req = 5'b01011;
    cyc();
    hd_req = '0;
    check("R6", "first lender bp", bpf(2), 1);
    check("R6", "second lender bp", bpf(4), 3);
    check("R6", "first lender state", st(2), 2);
    check("R6", "second lender state", st(4), 2);
    cyc();
    check("R6", "port1 vld", int'(rt_vld[1]), 1);
    check("R6", "port1 route E", prt(1), 0);
    check("R6", "port3 vld", int'(rt_vld[3]), 1);
    check("R6", "port3 route L", prt(3), 4);
  endtask

  task automatic t_stall();
    do_reset();
    hop_x = 3'd3; hop_y = 3'd3;
    mark_faulty(5'b00010);
    set_dst(1, 5, 3);
    hd_req[1] = 1'b1;
    cyc();
    hd_req[1] = 1'b0;
    set_dst(0, 3, 5);
    hd_req[0] = 1'b1;
    #1;
    check("R8", "stall raised", int'(stall[0]), 1);
    cyc();
    check("R8", "refused, no result", int'(rt_vld[0]), 0);
    check("R5", "borrower result", int'(rt_vld[1]), 1);
    check("R5", "borrower port E", prt(1), 0);
    #1;
    check("R8", "stall clears on retry", int'(stall[0]), 0);
    cyc();
    hd_req[0] = 1'b0;
    check("R8", "retry result", int'(rt_vld[0]), 1);
    check("R8", "retry port N", prt(0), 2);
  endtask

  task automatic t_fallback();
    do_reset();
    hop_x = 3'd3; hop_y = 3'd3;
    mark_faulty(5'b01010);
    set_dst(0, 6, 3); set_dst(2, 3, 6); set_dst(4, 0, 0);
    set_dst(1, 7, 7); set_dst(3, 0, 7);
    la_route[1*PW +: PW] = 3'd3;
    la_route[3*PW +: PW] = 3'd1;
    hd_req = 5'b11111;
    cyc();
    hd_req = '0;
    check("R7", "port1 vld", int'(rt_vld[1]), 1);
    check("R7", "port1 dbl", int'(rt_dbl[1]), 1);
    check("R7", "port1 lookahead", prt(1), 3);
    check("R7", "port3 dbl", int'(rt_dbl[3]), 1);
    check("R7", "port3 lookahead", prt(3), 1);
    check("R7", "healthy not flagged", int'(rt_dbl[0]), 0);
    check("R7", "port1 unit still faulty", st(1), 3);
    cyc();
    check("R7", "no late borrow result", int'(rt_vld[1]), 0);
  endtask

  initial begin
    t_reset();
    t_local();
    t_fault_mark();
    t_borrow();
    t_borrow_skip();
    t_multi();
    t_stall();
    t_fallback();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule